// File: doc/BRIEF.md
# Two-Wire Master Interrupt Status and Vector Unit

This unit gathers the event flags raised by the transfer engine of a two-wire bus master and presents them to software through a small 16-bit register port. Each event pulse sets a sticky bit in a status word. Software clears a bit by writing a one to it. A per-bit enable word selects which events drive a single level interrupt line. A third register returns a small code for the most urgent pending enabled event. Reading that register clears the event it names, so an interrupt handler can drain events one at a time without having to compute a clear mask.

The register port has three addresses: 0 is status, 1 is enable, 2 is vector, and 3 is reserved. A write takes effect at the clock edge where `wr_en_i` is high. A read is requested by `rd_en_i`. Its data comes back one cycle later, marked by `rd_valid_o`. The port is valid-only and has no back-pressure: every read is answered in exactly one cycle, so the requester must always accept the returned word. A read and a write may share a cycle.

Top module: `twi_event_irq`

## Requirements
- R1: A pulse on `evt_i` bit k latches status bit k for k in {0,1,2,3,4,8,9,10,11,13,14}. These are arbitration lost (0), no-acknowledge (1), access ready (2), receive ready (3), transmit ready (4), address-zero (8), addressed-as-slave (9), transmit underflow (10), receive overrun (11), receive drain (13) and transmit drain (14). Pulses on bits 5, 6, 7, 12 and 15 have no effect.
- R2: Writing the status address (0) clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: When an event pulse and a clear (by write or by vector read) hit the same bit in the same cycle, the bit ends up set.
- R4: The enable register (address 1) stores only bits 0-4, 13 and 14 of the written word. All other bits read back as 0.
- R5: `irq_o` is a register that, one cycle after any status bit and its enable bit are both 1 (bits 0-4, 13, 14), goes high. It goes low one cycle after no such pair remains.
- R6: Reading address 2 returns 0 when no enabled bit among status bits 0-4 is pending. Otherwise it returns the bit index plus 1 (1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready) of the lowest pending enabled bit.
- R7: A read of address 2 clears only the status bit that it reports. It clears nothing when it reports 0.
- R8: Status bit 12 is a live copy of `bus_busy_i` at the read cycle. It is never latched and never causes an interrupt.
- R9: Reset clears status, enable, the vector, `irq_o` and `rd_valid_o`.
- R10: A read request at a clock edge yields `rd_valid_o` high with the data in the following cycle. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 16 | One-cycle event pulses from the transfer engine, by status bit position |
| bus_busy_i | input | 1 | Live bus-occupied indication |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read request |
| addr_i | input | 2 | Register address: 0 status, 1 enable, 2 vector, 3 reserved |
| wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Registered level interrupt |

## Verification
On every cycle the assertions check the following: an event beats a simultaneous clear, a status write clears the ones it names, and the read-valid timing holds. They also check that the interrupt rises after an enabled pending bit appears, that enable and vector read-backs stay inside their legal values, and that bit 12 always mirrors the live busy input. Some behaviour only the bench's scenarios can show. That includes the exact drain order of the vector across several pending events, and the fact that a vector read leaves the other pending bits alone. It also includes the full contents of status after long mixes of random events, writes and reads, which the bench compares with its own reference model.

// File: rtl/twi_irq_pkg.sv
package twi_irq_pkg;
  localparam int DW      = 16;
  localparam int AW      = 2;
  localparam int NUM_VEC = 5;
  localparam int VW      = $clog2(NUM_VEC + 1);
  localparam int BUSY_BIT = 12;
  localparam logic [DW-1:0] LATCH_MASK = 16'h6F1F;
  localparam logic [DW-1:0] IRQ_MASK   = 16'h601F;

  typedef enum logic [AW-1:0] {
    ADR_STATUS = 2'd0,
    ADR_ENABLE = 2'd1,
    ADR_VECTOR = 2'd2,
    ADR_RSVD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/twi_irq_status.sv
module twi_irq_status #(
  parameter int              DW    = 16,
  parameter logic [DW-1:0]   LMASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] st_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (LMASK[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign st_o[i] = q;
    end else begin : g_tie
      assign st_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/twi_irq_enc.sv
module twi_irq_enc #(
  parameter int NV = 5,
  parameter int VW = 3
) (
  input  logic [NV-1:0] pend_i,
  output logic [VW-1:0] code_o,
  output logic [NV-1:0] hit_o
);
  always_comb begin
    code_o = '0;
    hit_o  = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = VW'(i + 1);
        hit_o  = NV'(1) << i;
      end
    end
  end
endmodule

// File: rtl/twi_irq_regif.sv
module twi_irq_regif
  import twi_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW-1:0]      status_i,
  input  logic               busy_i,
  input  logic [VW-1:0]      code_i,
  input  logic [NUM_VEC-1:0] hit_i,
  output logic [DW-1:0]      en_o,
  output logic [DW-1:0]      clr_o,
  output logic               rd_valid_o,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o
);
  reg_addr_e     sel;
  logic [DW-1:0] view_status;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] w1c;
  logic [DW-1:0] vclr;

  assign sel = reg_addr_e'(addr_i);

  always_comb begin
    view_status = status_i;
    view_status[BUSY_BIT] = busy_i;
  end

  assign w1c  = (wr_en_i && sel == ADR_STATUS) ? wdata_i : '0;
  assign vclr = (rd_en_i && sel == ADR_VECTOR) ? DW'(hit_i) : '0;
  assign clr_o = (w1c | vclr) & LATCH_MASK;

  always_comb begin
    unique case (sel)
      ADR_STATUS: rd_mux = view_status;
      ADR_ENABLE: rd_mux = en_o;
      ADR_VECTOR: rd_mux = DW'(code_i);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o       <= '0;
      rd_valid_o <= 1'b0;
      rdata_o    <= '0;
      irq_o      <= 1'b0;
    end else begin
      if (wr_en_i && sel == ADR_ENABLE) en_o <= wdata_i & IRQ_MASK;
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
      irq_o <= |(status_i & en_o & IRQ_MASK);
    end
  end
endmodule

// File: rtl/twi_event_irq.sv
module twi_event_irq
  import twi_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   evt_i,
  input  logic          bus_busy_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [15:0]   wdata_i,
  output logic          rd_valid_o,
  output logic [15:0]   rdata_o,
  output logic          irq_o
);
  logic [DW-1:0]      status_q;
  logic [DW-1:0]      en_q;
  logic [DW-1:0]      clr;
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] hit;
  logic [VW-1:0]      code;

  twi_irq_status #(.DW(DW), .LMASK(LATCH_MASK)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_i & LATCH_MASK),
    .clr_i (clr),
    .st_o  (status_q)
  );

  assign pend = status_q[NUM_VEC-1:0] & en_q[NUM_VEC-1:0];

  twi_irq_enc #(.NV(NUM_VEC), .VW(VW)) u_enc (
    .pend_i (pend),
    .code_o (code),
    .hit_o  (hit)
  );

  twi_irq_regif u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .status_i   (status_q),
    .busy_i     (bus_busy_i),
    .code_i     (code),
    .hit_i      (hit),
    .en_o       (en_q),
    .clr_o      (clr),
    .rd_valid_o (rd_valid_o),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/twi_event_irq_chk.sv
module twi_event_irq_chk
  import twi_irq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   evt_i,
  input logic          bus_busy_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [1:0]    addr_i,
  input logic [15:0]   wdata_i,
  input logic          rd_valid_o,
  input logic [15:0]   rdata_o,
  input logic          irq_o,
  input logic [15:0]   status_q,
  input logic [15:0]   en_q
);
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & LATCH_MASK)) |=> ((status_q & $past(evt_i & LATCH_MASK)) == $past(evt_i & LATCH_MASK))); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd0 && (evt_i & wdata_i) == 16'h0) |=> ((status_q & $past(wdata_i)) == 16'h0)); // R2

  AST_RD_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o); // R10

  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o); // R10

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_q & IRQ_MASK) != 16'h0) |=> irq_o); // R5

  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_q & IRQ_MASK) == 16'h0) |=> !irq_o); // R5

  AST_EN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == 2'd1) |=> ((rdata_o & ~IRQ_MASK) == 16'h0)); // R4

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == 2'd2) |=> (rdata_o <= 16'd5)); // R6

  AST_BUSY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == 2'd0) |=> (rdata_o[12] == $past(bus_busy_i))); // R8
endmodule

bind twi_event_irq twi_event_irq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .bus_busy_i (bus_busy_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rd_valid_o (rd_valid_o),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .status_q   (status_q),
  .en_q       (en_q)
);

// File: tb/twi_event_irq_test.sv
module twi_event_irq_test;
  localparam logic [15:0] LM = 16'h6F1F;
  localparam logic [15:0] EM = 16'h601F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_i = '0;
  logic        bus_busy_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        rd_valid_o;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] last_rd;

  always #10 clk = ~clk;

  twi_event_irq uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_busy_i(bus_busy_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_valid_o(rd_valid_o), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // reference model built from the requirements
  logic [15:0] m_st, m_en, m_rd;
  logic        m_irq, m_rdv;

  function automatic logic [2:0] vec_of(input logic [15:0] st, input logic [15:0] en);
    logic [2:0] c = 3'd0;
    for (int i = 4; i >= 0; i--) if (st[i] && en[i]) c = 3'(i + 1);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_st <= '0; m_en <= '0; m_rd <= '0; m_irq <= 1'b0; m_rdv <= 1'b0;
    end else begin
      logic [15:0] clr;
      logic [2:0]  c;
      c   = vec_of(m_st, m_en);
      clr = '0;
      if (wr_en_i && addr_i == 2'd0) clr = clr | wdata_i;
      if (rd_en_i && addr_i == 2'd2 && c != 3'd0) clr = clr | (16'h1 << (c - 3'd1));
      m_st  <= ((m_st & ~clr) | evt_i) & LM;
      if (wr_en_i && addr_i == 2'd1) m_en <= wdata_i & EM;
      m_irq <= |(m_st & m_en & EM);
      m_rdv <= rd_en_i;
      if (rd_en_i) begin
        case (addr_i)
          2'd0: m_rd <= m_st | (16'(bus_busy_i) << 12);
          2'd1: m_rd <= m_en;
          2'd2: m_rd <= 16'(c);
          default: m_rd <= '0;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: compare outputs at the falling edge, then drive next inputs
  task automatic tick(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [15:0] wd, input logic [15:0] ev, input logic bb);
    @(negedge clk);
    check("R5 irq", 16'(irq_o), 16'(m_irq));
    check("R10 rd_valid", 16'(rd_valid_o), 16'(m_rdv));
    if (m_rdv) check("R1/R2/R6/R7 rdata", rdata_o, m_rd);
    last_rd = rdata_o;
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = wd; evt_i = ev; bus_busy_i = bb;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    tick(1'b0, 1'b1, a, '0, '0, bus_busy_i);
    tick(1'b0, 1'b0, '0, '0, '0, bus_busy_i);
    d = last_rd;
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R9 irq in reset", 16'(irq_o), 16'h0);
    check("R9 rd_valid in reset", 16'(rd_valid_o), 16'h0);
    rst_n = 1'b1;
    rd_reg(2'd0, d); check("R9 status after reset", d, 16'h0);
    rd_reg(2'd1, d); check("R9 enable after reset", d, 16'h0);
    rd_reg(2'd2, d); check("R9 vector after reset", d, 16'h0);

    // R4 enable mask
    tick(1'b1, 1'b0, 2'd1, 16'hFFFF, '0, 1'b0);
    rd_reg(2'd1, d); check("R4 enable readback", d, 16'h601F);

    // R1 all bits pulsed, ignored bits stay clear; R8 busy live
    tick(1'b0, 1'b0, '0, '0, 16'hFFFF, 1'b1);
    rd_reg(2'd0, d); check("R1/R8 status latch", d, 16'h7F1F);
    bus_busy_i = 1'b0;
    rd_reg(2'd0, d); check("R8 busy not latched", d, 16'h6F1F);

    // R6/R7 drain order
    for (int k = 1; k <= 5; k++) begin
      rd_reg(2'd2, d); check("R6 vector order", d, 16'(k));
    end
    rd_reg(2'd2, d); check("R6 vector none", d, 16'h0);
    rd_reg(2'd0, d); check("R7 others kept", d, 16'h6F00);

    // R2 W1C partial, R3 event wins
    tick(1'b1, 1'b0, 2'd0, 16'h0300, 16'h0200, 1'b0);
    rd_reg(2'd0, d); check("R2/R3 w1c with collision", d, 16'h6E00);
    tick(1'b1, 1'b0, 2'd0, 16'h0000, '0, 1'b0);
    rd_reg(2'd0, d); check("R2 zero write", d, 16'h6E00);
    tick(1'b1, 1'b0, 2'd0, 16'hFFFF, '0, 1'b0);
    rd_reg(2'd0, d); check("R2 full clear", d, 16'h0000);
    check("R5 irq cleared", 16'(irq_o), 16'h0);

    // R10 reserved address
    rd_reg(2'd3, d); check("R10 reserved reads 0", d, 16'h0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ev;
      logic [31:0] r;
      r  = $urandom;
      ev = 16'($urandom & $urandom & $urandom);
      tick(r[3:0] == 4'd0, r[5:4] != 2'd0, r[7:6],
           (r[8] ? 16'($urandom) : 16'hFFFF), ev, r[9]);
    end

    // R9 reset mid-run
    tick(1'b0, 1'b0, '0, '0, 16'h001F, 1'b0);
    rst_n = 1'b0;
    tick(1'b0, 1'b0, '0, '0, '0, 1'b0);
    rst_n = 1'b1;
    rd_reg(2'd0, d); check("R9 status after mid reset", d, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule